// File: doc/BRIEF.md
# TLB Fault Exception Entry

This unit performs the state update a processor makes when address translation fails, either on instruction fetch or on a data access. When a fault strobe arrives it captures the faulting effective address as the return address, builds a saved status word from the fault cause and the low half of the current machine state, rewrites the machine state for the handler, and emits a one-cycle redirect with the handler address.

Bit numbers in this brief count from the MSB: bit 0 is the most significant bit of a 32-bit word, so bit k sits at vector index 31-k. The machine state fields it uses are ILE (bit 15), ME (bit 19), IP (bit 25), IR (bit 26), RI (bit 30) and LE (bit 31). The surrounding pipeline supplies fault strobes and cause flags, and it consumes the registered results on the cycle the redirect pulse is high.

Top module: `tlb_fault_entry`

## Requirements
- R1: While `rst_n` is low, all outputs are zero.
- R2: A fault strobe sampled at a clock edge makes `redirect_valid_o` high for exactly the following cycle, with `save_pc_o` equal to the sampled `fault_ea_i`.
- R3: On each fault, bits 16–31 of `save_stat_o` equal bits 16–31 of the sampled `msr_i`. This includes bit 30, which is zero only if RI was zero.
- R4: An instruction fault with `ifault_miss_i` set writes status bit 1 (value 0x40000000).
- R5: An instruction fault with `ifault_guard_i` set writes status bit 3 (0x10000000) only when IR is 1. With IR at 0 the guard flag has no effect.
- R6: An instruction fault with only `ifault_prot_i` set writes status bit 4 (0x08000000).
- R7: When an instruction fault has more than one cause flag, only one cause bit is written, chosen in the order missing translation, guarded fetch, protection.
- R8: On a data fault, status bits 0–15 are all zero, whatever the cause flags say.
- R9: The new machine state keeps IP and ME, sets LE to the old ILE, and clears every other bit.
- R10: The redirect target is 0x1300 for an instruction fault and 0x1400 for a data fault. When the sampled IP is 1, 0xFFF00000 is added to it.
- R11: If both strobes are high in the same cycle, the fault is handled as an instruction fault.
- R12: In a cycle with no fault strobe, `redirect_valid_o` stays low and the saved address, status, new machine state and target all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ifault_i | input | 1 | Instruction translation fault strobe |
| ifault_miss_i | input | 1 | Fetch translation absent from the tables |
| ifault_guard_i | input | 1 | Fetch targeted guarded memory |
| ifault_prot_i | input | 1 | Fetch denied by protection |
| dfault_i | input | 1 | Data translation fault strobe |
| fault_ea_i | input | 32 | Effective address of the faulting instruction |
| msr_i | input | 32 | Current machine state |
| save_pc_o | output | 32 | Saved return address |
| save_stat_o | output | 32 | Saved status word |
| msr_o | output | 32 | Machine state for the handler |
| redirect_valid_o | output | 1 | One-cycle redirect pulse |
| redirect_pc_o | output | 32 | Handler address |

## Verification
Every output is a register loaded on the edge that samples a fault, so a wrong cause selection, a missing machine state copy or a wrong vector base shows up in the cycle right after that strobe, on the same pulse. A wrong idle path shows up as a stray pulse, or as saved values drifting during quiet cycles. The scoreboard compares all four words on every pulse and flags any missing or extra pulse on the next sampling point.

// File: rtl/tlb_fault_entry.sv
module tlb_fault_entry #(
  parameter logic [31:0] HI_BASE = 32'hFFF0_0000,
  parameter logic [31:0] I_OFS   = 32'h0000_1300,
  parameter logic [31:0] D_OFS   = 32'h0000_1400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ifault_i,
  input  logic        ifault_miss_i,
  input  logic        ifault_guard_i,
  input  logic        ifault_prot_i,
  input  logic        dfault_i,
  input  logic [31:0] fault_ea_i,
  input  logic [31:0] msr_i,
  output logic [31:0] save_pc_o,
  output logic [31:0] save_stat_o,
  output logic [31:0] msr_o,
  output logic        redirect_valid_o,
  output logic [31:0] redirect_pc_o
);
  // vector indices for MSB-first bit numbers (index = 31 - bit)
  localparam int P_ILE  = 31 - 15;
  localparam int P_ME   = 31 - 19;
  localparam int P_IP   = 31 - 25;
  localparam int P_IR   = 31 - 26;
  localparam int P_RI   = 31 - 30;
  localparam int P_LE   = 31 - 31;
  localparam int C_MISS = 31 - 1;
  localparam int C_GRD  = 31 - 3;
  localparam int C_PROT = 31 - 4;

  logic        any_f, take_i, guard_q;
  logic [31:0] stat_n, msr_n, pc_n;

  assign any_f   = ifault_i | dfault_i;
  assign take_i  = ifault_i;
  assign guard_q = ifault_guard_i & msr_i[P_IR];

  always_comb begin
    stat_n = {16'h0000, msr_i[15:0]};
    if (take_i) begin
      if (ifault_miss_i)      stat_n[C_MISS] = 1'b1;
      else if (guard_q)       stat_n[C_GRD]  = 1'b1;
      else if (ifault_prot_i) stat_n[C_PROT] = 1'b1;
    end
  end

  always_comb begin
    msr_n        = '0;
    msr_n[P_IP]  = msr_i[P_IP];
    msr_n[P_ME]  = msr_i[P_ME];
    msr_n[P_LE]  = msr_i[P_ILE];
  end

  assign pc_n = (msr_i[P_IP] ? HI_BASE : 32'h0) + (take_i ? I_OFS : D_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      save_pc_o        <= '0;
      save_stat_o      <= '0;
      msr_o            <= '0;
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
    end else begin
      redirect_valid_o <= any_f;
      if (any_f) begin
        save_pc_o     <= fault_ea_i;
        save_stat_o   <= stat_n;
        msr_o         <= msr_n;
        redirect_pc_o <= pc_n;
      end
    end
  end

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> $past(ifault_i | dfault_i));
  assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ifault_i | dfault_i) |=> (redirect_valid_o && save_pc_o == $past(fault_ea_i)));
  assert_low_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> (save_stat_o[15:0] == $past(msr_i[15:0])));
  assert_cause_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> $onehot0({save_stat_o[C_MISS], save_stat_o[C_GRD], save_stat_o[C_PROT]}));
  assert_data_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid_o && !$past(ifault_i)) |-> (save_stat_o[31:16] == 16'h0));
  assert_msr_rewrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> ($countones(msr_o) <= 3 && msr_o[P_LE] == $past(msr_i[P_ILE])));
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifault_i | dfault_i) |=> (!redirect_valid_o && $stable(save_pc_o) && $stable(save_stat_o)));
endmodule

// File: tb/tlb_fault_entry_tb.sv
module tlb_fault_entry_tb;
  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] stat;
    logic [31:0] msr;
    logic [31:0] tgt;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ifault = 0, imiss = 0, igrd = 0, iprot = 0, dfault = 0;
  logic [31:0] ea = '0, msr = '0;
  logic [31:0] save_pc, save_stat, msr_out, rpc;
  logic        rvalid;
  int checks = 0, fails = 0;
  exp_t q[$];
  exp_t last;
  string tag_q[$];

  always #4 clk = ~clk;

  tlb_fault_entry u_dut (
    .clk(clk), .rst_n(rst_n), .ifault_i(ifault), .ifault_miss_i(imiss),
    .ifault_guard_i(igrd), .ifault_prot_i(iprot), .dfault_i(dfault),
    .fault_ea_i(ea), .msr_i(msr), .save_pc_o(save_pc), .save_stat_o(save_stat),
    .msr_o(msr_out), .redirect_valid_o(rvalid), .redirect_pc_o(rpc));

  function automatic logic bitn(logic [31:0] w, int k);
    return w[31-k];
  endfunction

  function automatic exp_t model(logic i, logic m, logic g, logic p,
                                 logic [31:0] a, logic [31:0] s);
    exp_t e;
    e.pc = a;
    e.stat = s & 32'h0000_FFFF;
    if (i) begin
      if (m)                     e.stat |= 32'h4000_0000;
      else if (g && bitn(s, 26)) e.stat |= 32'h1000_0000;
      else if (p)                e.stat |= 32'h0800_0000;
    end
    e.msr = 32'h0;
    if (bitn(s, 25)) e.msr |= 32'h0000_0040;
    if (bitn(s, 19)) e.msr |= 32'h0000_1000;
    if (bitn(s, 15)) e.msr |= 32'h0000_0001;
    e.tgt = (bitn(s, 25) ? 32'hFFF0_0000 : 32'h0) + (i ? 32'h1300 : 32'h1400);
    return e;
  endfunction

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic fire(string r, logic i, logic m, logic g, logic p, logic d,
                      logic [31:0] a, logic [31:0] s);
    @(negedge clk);
    ifault = i; imiss = m; igrd = g; iprot = p; dfault = d; ea = a; msr = s;
    @(posedge clk);
    q.push_back(model(i, m, g, p, a, s));
    tag_q.push_back(r);
    @(negedge clk);
    ifault = 0; imiss = 0; igrd = 0; iprot = 0; dfault = 0;
    ea = $urandom; msr = $urandom;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        if (q.size() == 0) chk("R12", "stray pulse", 32'd1, 32'd0);
        else begin
          exp_t e;
          string r;
          e = q.pop_front();
          r = tag_q.pop_front();
          last = e;
          chk(r, "save_pc", save_pc, e.pc);
          chk(r, "save_stat", save_stat, e.stat);
          chk(r, "msr_o", msr_out, e.msr);
          chk(r, "redirect_pc", rpc, e.tgt);
        end
      end else if (q.size() != 0) begin
        chk("R2", "missing pulse", 32'd0, 32'd1);
        void'(q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset pulse", {31'd0, rvalid}, 32'd0);
    chk("R1", "reset save_pc", save_pc, 32'd0);
    chk("R1", "reset save_stat", save_stat, 32'd0);
    chk("R1", "reset msr/tgt", msr_out | rpc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 R2 R3 R9: missing translation, RI=1, ILE=1, ME=1
    fire("R4", 1, 1, 0, 0, 0, 32'h1234_5678, 32'h0001_1023);
    // R5: guard with IR=1
    fire("R5", 1, 0, 1, 0, 0, 32'h0000_4000, 32'h0000_0022);
    // R5: guard with IR=0 has no effect
    fire("R5", 1, 0, 1, 0, 0, 32'h0000_4004, 32'h0000_1002);
    // R6: protection, RI=0
    fire("R6", 1, 0, 0, 1, 0, 32'hDEAD_BEE0, 32'h0001_0000);
    // R7: all causes -> missing only; guard+prot with IR -> guard only
    fire("R7", 1, 1, 1, 1, 0, 32'hA000_0010, 32'h0000_0020);
    fire("R7", 1, 0, 1, 1, 0, 32'hA000_0020, 32'hFFFF_FFFF);
    // R8: data fault ignores cause flags
    fire("R8", 0, 1, 1, 1, 1, 32'h8000_0008, 32'hFFFF_FFFF);
    // R10: IP selects high base, both paths
    fire("R10", 1, 0, 0, 1, 0, 32'h0000_0100, 32'h0000_0040);
    fire("R10", 0, 0, 0, 0, 1, 32'h0000_0200, 32'h0000_0040);
    fire("R10", 0, 0, 0, 0, 1, 32'h0000_0300, 32'h0000_0000);
    // R11: both strobes -> instruction fault
    fire("R11", 1, 0, 0, 1, 1, 32'h5555_0000, 32'h0000_1003);
    // R9 R3: ME/IP/ILE kept, RI=0 keeps bit 30 clear
    fire("R9", 0, 0, 0, 0, 1, 32'h0F0F_0F0F, 32'hFFFF_FFFD);
    // R12: idle cycles keep outputs
    repeat (5) @(negedge clk);
    chk("R12", "held save_pc", save_pc, last.pc);
    chk("R12", "held save_stat", save_stat, last.stat);
    chk("R12", "held msr/tgt", msr_out ^ rpc, last.msr ^ last.tgt);
    chk("R12", "no pulse", {31'd0, rvalid}, 32'd0);
    chk("R2", "queue drained", q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule